// File: doc/BRIEF.md
# PCM bit-clock and frame-sync generator

This block makes the two timing signals a PCM audio port needs: a serial bit clock and a frame-sync pulse. It runs entirely on one system clock. Each candidate clock source arrives as a one-cycle tick, and a select bit in the control word picks one of them. One divider stage toggles the bit clock after a programmable number of selected ticks. A second stage counts bit-clock rising edges and marks each frame with a pulse that lasts one bit-clock period.

A bus writes a 32-bit control word and reads it back. The word holds a run enable, the source select and two 9-bit divide values. While the enable is clear, both counters sit at zero and both outputs stay low. Setting the enable restarts both stages from count zero. When a divide value changes while the stage runs, the new value is used from the next wrap of that stage, so no period comes out short.

Top module: `pcm_clkgen`

## Requirements
- R1: After reset the control word reads back as zero, and the bit clock and the frame-sync are low.
- R2: Control word bit positions are: bit 19 run enable, bit 18 source select, bits [17:9] bit-clock divide value B, bits [8:0] frame-sync divide value F. A write stores bits [19:0], and they read back unchanged on the next cycle. Bits [31:20] always read as zero.
- R3: With the source select at 0, the bit clock advances only on external ticks. With the select at 1, it advances only on internal ticks. Ticks on the source that is not selected have no effect.
- R4: While running, the bit clock stays in each level for exactly B+1 selected ticks. Its period is therefore 2*(B+1) ticks at a 50% duty cycle.
- R5: While running with F>0, the frame-sync rises together with a bit-clock rising edge. It repeats every F+1 bit-clock periods and stays high for one bit-clock period.
- R6: With F=0, the frame-sync is asserted in every bit-clock period, so it stays high while the block runs.
- R7: Clearing the run enable drives both outputs low by the second clock edge after the write. They stay low while the enable is clear, even while ticks arrive.
- R8: After the run enable is set, counting begins at the second clock edge after the write. The first bit-clock rise comes on the (B+1)th selected tick from there. The first frame-sync comes with the (F+1)th bit-clock rise.
- R9: A divide value written while the block runs takes effect at the next wrap of its stage. The level in progress finishes with the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | One-cycle tick from the external clock source |
| int_tick | input | 1 | One-cycle tick from the internal peripheral clock |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame-sync pulse |

## Verification
The hardest case to reach is a divide value that changes partway through a bit-clock level. The write has to land in a cycle that lies strictly between two wraps. To get there, the bench watches the bit clock on the falling system-clock edge. It issues the new divide value in the same cycle that it first sees the bit clock high. Then it measures the lengths of the current level and the following levels. This shows whether the running level kept the old length and every later level took the new one. The restart latency is measured in the same way, cycle by cycle from the enabling write, with an internal tick in every cycle.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  parameter int DIV_W = 9;

  // bit 19 run, bit 18 source, [17:9] bit-clock divide, [8:0] frame divide
  typedef struct packed {
    logic             run_en;
    logic             src_int;
    logic [DIV_W-1:0] bdiv;
    logic [DIV_W-1:0] fdiv;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // true when a stage counter has reached its latched limit
  function automatic logic at_limit(input logic [DIV_W-1:0] cnt,
                                    input logic [DIV_W-1:0] lim);
    return cnt == lim;
  endfunction

  // next counter value for one step of a stage
  function automatic logic [DIV_W-1:0] step_count(input logic [DIV_W-1:0] cnt,
                                                  input logic [DIV_W-1:0] lim);
    return at_limit(cnt, lim) ? '0 : cnt + DIV_W'(1);
  endfunction

endpackage

// File: rtl/pcm_ctrl_reg.sv
module pcm_ctrl_reg
  import pcm_clkgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl
);

  localparam logic [DATA_W-1:0] KEEP = DATA_W'((64'd1 << CTRL_W) - 64'd1);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data & KEEP;
  end

  assign rd_data = word_q;
  assign ctrl    = ctrl_t'(word_q[CTRL_W-1:0]);

endmodule

// File: rtl/pcm_div_stage.sv
module pcm_div_stage
  import pcm_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] lim_in,
  output logic             wrap,
  output logic [DIV_W-1:0] cnt_q,
  output logic [DIV_W-1:0] lim_q
);

  assign wrap = run && step && at_limit(cnt_q, lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      lim_q <= lim_in;
    end else if (step) begin
      cnt_q <= step_count(cnt_q, lim_q);
      if (wrap) lim_q <= lim_in;
    end
  end

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_clkgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              int_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              bclk_o,
  output logic              fsync_o
);

  ctrl_t            ctrl;
  logic             run_q;
  logic             src_tick;
  logic             bwrap;
  logic             bclk_rise;
  logic             fwrap;
  logic [DIV_W-1:0] bcnt;
  logic [DIV_W-1:0] blim;
  logic [DIV_W-1:0] fcnt;
  logic [DIV_W-1:0] flim;

  pcm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ctrl    (ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= ctrl.run_en;
  end

  assign src_tick = ctrl.src_int ? int_tick : ext_tick;

  pcm_div_stage u_bstage (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .step   (src_tick),
    .lim_in (ctrl.bdiv),
    .wrap   (bwrap),
    .cnt_q  (bcnt),
    .lim_q  (blim)
  );

  assign bclk_rise = bwrap && !bclk_o;

  pcm_div_stage u_fstage (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .step   (bclk_rise),
    .lim_in (ctrl.fdiv),
    .wrap   (fwrap),
    .cnt_q  (fcnt),
    .lim_q  (flim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (!run_q) begin
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else begin
      if (bwrap)     bclk_o  <= !bclk_o;
      if (bclk_rise) fsync_o <= fwrap;
    end
  end

endmodule

// File: rtl/pcm_clkgen_chk.sv
module pcm_clkgen_chk
  import pcm_clkgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              bclk_o,
  input logic              fsync_o,
  input logic              run_q,
  input logic              src_tick,
  input logic [DIV_W-1:0]  bcnt,
  input logic [DIV_W-1:0]  blim,
  input logic [DIV_W-1:0]  fcnt,
  input logic [DIV_W-1:0]  flim
);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CTRL_W-1:0] == $past(wr_data[CTRL_W-1:0]))
              && (rd_data[DATA_W-1:CTRL_W] == '0));

  assert_src_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_o != $past(bclk_o)) |-> ($past(src_tick) || !$past(run_q)));

  assert_bcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= blim);

  assert_fcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= flim);

  assert_fsync_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> $rose(bclk_o));

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[CTRL_W-1] |=> ##1 (!bclk_o && !fsync_o));

endmodule

bind pcm_clkgen pcm_clkgen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_pcm_clkgen.sv
module test_pcm_clkgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        int_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bclk_o;
  logic        fsync_o;

  int n_chk = 0;
  int n_bad = 0;
  int int_gap = 0;
  int ext_gap = 0;
  int icnt = 0;
  int ecnt = 0;
  int cyc = 0;

  always #4 clk = !clk;

  pcm_clkgen i_pcm_clkgen (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .int_tick(int_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bclk_o(bclk_o), .fsync_o(fsync_o)
  );

  // tick sources: one tick every gap cycles, none when gap is 0
  always @(negedge clk) begin
    if (int_gap == 0) int_tick = 1'b0;
    else if (icnt >= int_gap - 1) begin icnt = 0; int_tick = 1'b1; end
    else begin icnt++; int_tick = 1'b0; end
    if (ext_gap == 0) ext_tick = 1'b0;
    else if (ecnt >= ext_gap - 1) begin ecnt = 0; ext_tick = 1'b1; end
    else begin ecnt++; ext_tick = 1'b0; end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit src,
                                     input int bd, input int fd);
    return {12'h000, en, src, bd[8:0], fd[8:0]};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic sig(input bit fs);
    return fs ? fsync_o : bclk_o;
  endfunction

  task automatic wait_rise(input bit fs);
    logic prev;
    int n = 0;
    prev = sig(fs);
    @(negedge clk);
    while (!((prev == 1'b0) && (sig(fs) == 1'b1)) && n < 20000) begin
      prev = sig(fs); n++; @(negedge clk);
    end
  endtask

  task automatic run_len(input bit fs, input logic lvl, output int n);
    n = 0;
    while (sig(fs) === lvl && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 control word after reset", rd_data, 0);
    chk("R1 bclk after reset", bclk_o, 0);
    chk("R1 fsync after reset", fsync_o, 0);
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF);
    chk("R2 readback all ones, reserved zero", rd_data, 32'h000F_FFFF);
    wr(mk(0, 1, 9'h155, 9'h0AA));
    chk("R2 readback fields", rd_data, 32'h0006_AA00 | 32'h0000_00AA);
    wr(32'h0);
  endtask

  task automatic t_period(input bit src, input int gap, input int bd, input int fd);
    int h, l, fp, fh;
    int bp;
    wr(mk(0, src, bd, fd));
    int_gap = src ? gap : 1;
    ext_gap = src ? 0 : gap;
    wr(mk(1, src, bd, fd));
    wait_rise(0);
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    chk("R4 bclk high length", h, (bd + 1) * gap);
    chk("R4 bclk low length", l, (bd + 1) * gap);
    bp = 2 * (bd + 1) * gap;
    wait_rise(1);
    run_len(1, 1'b1, fh);
    run_len(1, 1'b0, fp);
    chk("R5 fsync high width", fh, bp);
    chk("R5 fsync period", fh + fp, (fd + 1) * bp);
    wr(mk(0, src, bd, fd));
  endtask

  task automatic t_src_ignore();
    int toggles = 0;
    logic prev;
    wr(mk(0, 0, 1, 1));
    ext_gap = 0; int_gap = 1;
    wr(mk(1, 0, 1, 1));
    prev = bclk_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bclk_o != prev) toggles++;
      prev = bclk_o;
    end
    chk("R3 internal ticks ignored with external selected", toggles, 0);
    chk("R3 bclk still low", bclk_o, 0);
    wr(mk(0, 1, 1, 1));
    int_gap = 0; ext_gap = 1;
    wr(mk(1, 1, 1, 1));
    toggles = 0;
    prev = bclk_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bclk_o != prev) toggles++;
      prev = bclk_o;
    end
    chk("R3 external ticks ignored with internal selected", toggles, 0);
    wr(mk(0, 1, 1, 1));
    ext_gap = 0;
  endtask

  task automatic t_fdiv_zero();
    int lows = 0;
    wr(mk(0, 1, 2, 0));
    int_gap = 1;
    wr(mk(1, 1, 2, 0));
    wait_rise(0);
    for (int i = 0; i < 60; i++) begin
      if (!fsync_o) lows++;
      @(negedge clk);
    end
    chk("R6 fsync held high with zero frame divide", lows, 0);
    wr(mk(0, 1, 2, 0));
  endtask

  task automatic t_stop();
    int highs = 0;
    wr(mk(0, 1, 0, 1));
    int_gap = 1; ext_gap = 1;
    wr(mk(1, 1, 0, 1));
    repeat (13) @(negedge clk);
    wr(mk(0, 1, 0, 1));
    @(negedge clk);
    @(negedge clk);
    chk("R7 bclk low two edges after stop", bclk_o, 0);
    chk("R7 fsync low two edges after stop", fsync_o, 0);
    for (int i = 0; i < 50; i++) begin
      if (bclk_o || fsync_o) highs++;
      @(negedge clk);
    end
    chk("R7 outputs stay low while stopped", highs, 0);
    ext_gap = 0;
  endtask

  task automatic t_restart(input int bd, input int fd);
    int n = 0;
    int rises = 0;
    wr(mk(0, 1, bd, fd));
    int_gap = 1;
    repeat (4) @(negedge clk);
    wr(mk(1, 1, bd, fd));
    do begin @(negedge clk); n++; end while (!bclk_o && n < 5000);
    chk("R8 cycles to first bclk rise after enable", n, bd + 2);
    rises = 1;
    while (!fsync_o && rises < 600) begin wait_rise(0); rises++; end
    chk("R8 bclk rise carrying first fsync", rises, fd + 1);
    wr(mk(0, 1, bd, fd));
  endtask

  task automatic t_live_change();
    int h0, l1, h1;
    wr(mk(0, 1, 3, 1));
    int_gap = 1;
    wr(mk(1, 1, 3, 1));
    wait_rise(0);
    wr_en = 1'b1; wr_data = mk(1, 1, 7, 1);
    h0 = 0;
    while (bclk_o && h0 < 100) begin
      h0++; @(negedge clk); wr_en = 1'b0;
    end
    run_len(0, 1'b0, l1);
    run_len(0, 1'b1, h1);
    chk("R9 level in progress keeps old length", h0, 4);
    chk("R9 next low level uses new length", l1, 8);
    chk("R9 next high level uses new length", h1, 8);
    wr(mk(0, 1, 3, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_period(1, 1, 3, 2);
    t_period(0, 3, 1, 3);
    t_period(1, 2, 0, 1);
    t_src_ignore();
    t_fdiv_zero();
    t_stop();
    t_restart(5, 2);
    t_restart(0, 0);
    t_live_change();
    summary();
  end

endmodule